// File: doc/BRIEF.md
# Linked Hardware Breakpoint Match Unit

This block watches the instruction stream of a processor core and flags hardware breakpoints. It holds six breakpoint slots. Each slot pairs a 64-bit compare value with a 32-bit control word. Software or a debugger programs both words through a simple register port. For every instruction presented on the strobe input, the unit reports a registered 6-bit vector, one bit per slot, that shows which slots raise a breakpoint.

A slot can compare the instruction address or the current execution context. Address compares come in two forms, match and mismatch, and a mismatch slot falls back to plain matching while a mode input is high. Context compares can test the context identifier, the 8-bit virtual-machine identifier, or both. An address slot can also be chained by index to a context slot, so that it fires only inside one particular context. The control word has fields for security state and privilege level. They are stored and read back, but they do not filter anything here, so their filter always passes.

Top module: `bkpt_unit`

## Requirements
- R1: Each of the six slots, index 0 to 5, has a 64-bit value word and a control word. A write takes effect at the clock edge where `reg_wr` is high. `reg_ctrl`=1 selects the control word, which takes `reg_wdata[31:0]`; `reg_ctrl`=0 selects the value word, which takes all 64 bits. A read returns the selected word on `reg_rdata`, with `reg_rvalid` high, one cycle after `reg_rd`.
- R2: The control word fields are: bit 0 enable, bits [2:1] privilege filter, bits [8:5] halfword select, bit 13 hypervisor filter, bits [15:14] security filter, bits [19:16] link index, bits [23:20] type. Bits [4:3], [12:9] and [31:24] read as zero and ignore writes, and `reg_rdata[63:32]` is zero for a control read.
- R3: Bits 8 and 6 of the control word cannot be written on their own. Bit 8 reads back as bit 7, and bit 6 reads back as bit 5.
- R4: After reset every value and control word reads as zero, and `ev_valid` and `ev_hit` are zero.
- R5: An address compare tests `ins_addr[63:2]` against value bits [63:2] in full and ignores value bits [1:0]. It also needs the right halfword lane. Select 0x3 needs a 16-bit instruction (`ins_wide`=0) with `ins_addr[1]`=0. Select 0xC needs a 16-bit instruction with `ins_addr[1]`=1. Select 0xF needs a 32-bit instruction (`ins_wide`=1) with `ins_addr[1]`=0. Any other select value never matches.
- R6: A slot whose enable bit is 0 never sets its `ev_hit` bit.
- R7: Type bits [23:21] select the base kind: 000 address match, 001 context-ID match, 010 address mismatch, 100 VMID match, 101 VMID plus context-ID match. The context ID is compared with value bits [31:0] and the VMID with value bits [39:32]. The combined kind needs both to be equal.
- R8: An address-mismatch slot fires when the R5 address compare fails. While `mm_as_match` is 1 it fires exactly when the compare succeeds.
- R9: Type bit 20 marks a slot as linked. A linked address slot (type 0001 or 0101) fires only when four conditions hold: its own address condition holds; the slot named by its link index is enabled; that slot has a context base kind with its own link bit set; and that slot's context compare holds. A link index above 5 never fires.
- R10: A linked context slot (type 0011, 1001 or 1011) never sets its own `ev_hit` bit.
- R11: Type values other than 0000, 0001, 0010, 0011, 0100, 0101, 1000, 1001, 1010 and 1011 never fire.
- R12: `ev_valid` and `ev_hit` are registered. They show the result for the instruction strobed by `ins_valid` one cycle earlier, and `ev_hit` is zero whenever `ev_valid` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ctrl | input | 1 | 1 selects the control word, 0 selects the value word |
| reg_idx | input | 3 | Slot index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| reg_rvalid | output | 1 | Read data valid |
| ins_valid | input | 1 | Instruction strobe |
| ins_addr | input | 64 | Instruction address |
| ins_wide | input | 1 | 1 for a 32-bit instruction, 0 for a 16-bit one |
| ins_ctx | input | 32 | Current context identifier |
| ins_vmid | input | 8 | Current virtual-machine identifier |
| mm_as_match | input | 1 | Makes mismatch slots behave as match slots |
| ev_valid | output | 1 | Result valid, one cycle after `ins_valid` |
| ev_hit | output | 6 | Per-slot breakpoint event |

## Verification
Faults in the stored words show up in two ways. A wrong stored control or value bit shows up either on the next read, with the mirrored select bits and the zero fields as tell-tales, or as a missing or spurious `ev_hit` bit one cycle after the strobe of an instruction that reaches that slot's compare. A wrong link resolution shows up only when the target slot is also a linked context slot and its compare passes. So the chained cases are driven with the target disabled, unlinked, of the wrong kind and out of range, and each case is seen on the very next result.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam int CW_W  = 32;
  localparam int LBN_W = 4;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [3:0] kind;
    logic [3:0] lbn;
    logic [1:0] sec;
    logic       hyp;
    logic [3:0] rsv_mid;
    logic [3:0] lane;
    logic [1:0] rsv_lo;
    logic [1:0] priv;
    logic       en;
  } ctrl_t;

  typedef enum logic [2:0] {
    BK_ADDR = 3'b000,
    BK_CTX  = 3'b001,
    BK_MISM = 3'b010,
    BK_VMID = 3'b100,
    BK_VCTX = 3'b101
  } base_e;

  // Clear reserved fields and mirror the two non-writable select bits.
  function automatic ctrl_t ctrl_clean(input logic [CW_W-1:0] w);
    ctrl_t c;
    c         = ctrl_t'(w);
    c.rsv_hi  = '0;
    c.rsv_mid = '0;
    c.rsv_lo  = '0;
    c.lane[3] = c.lane[2];
    c.lane[1] = c.lane[0];
    return c;
  endfunction

  function automatic logic kind_known(input logic [3:0] k);
    case (k[3:1])
      BK_ADDR, BK_CTX, BK_MISM, BK_VMID, BK_VCTX: return 1'b1;
      default:                                    return 1'b0;
    endcase
  endfunction

  function automatic logic kind_is_ctx(input logic [3:0] k);
    return (k[3:1] == BK_CTX) || (k[3:1] == BK_VMID) || (k[3:1] == BK_VCTX);
  endfunction

  function automatic logic kind_is_addr(input logic [3:0] k);
    return (k[3:1] == BK_ADDR) || (k[3:1] == BK_MISM);
  endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int VAL_W     = 64,
  parameter int IDX_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr,
  input  logic                            rd,
  input  logic                            sel_ctrl,
  input  logic [IDX_W-1:0]                idx,
  input  logic [VAL_W-1:0]                wdata,
  output logic [VAL_W-1:0]                rdata,
  output logic                            rvalid,
  output logic [NUM_PAIRS-1:0][VAL_W-1:0] val_o,
  output ctrl_t [NUM_PAIRS-1:0]           ctrl_o
);

  logic [VAL_W-1:0] rd_mux;
  logic             rd_was_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
        val_o[i]  <= '0;
        ctrl_o[i] <= '0;
      end
    end else if (wr) begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
        if (idx == IDX_W'(i)) begin
          if (sel_ctrl) ctrl_o[i] <= ctrl_clean(wdata[CW_W-1:0]);
          else          val_o[i]  <= wdata;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_mux = sel_ctrl ? VAL_W'(ctrl_o[i]) : val_o[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      rvalid      <= 1'b0;
      rd_was_ctrl <= 1'b0;
    end else begin
      rvalid      <= rd;
      rd_was_ctrl <= sel_ctrl;
      if (rd) rdata <= rd_mux;
    end
  end

  // R3: select mirror seen on every control readback
  a_r3_lane_mirror: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rd_was_ctrl) |-> (rdata[8] == rdata[7] && rdata[6] == rdata[5]));

  // R2: reserved control bits always read as zero
  a_r2_res_zero: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rd_was_ctrl) |-> (rdata[4:3] == 2'b0 && rdata[12:9] == 4'b0
                                 && rdata[VAL_W-1:24] == '0));

endmodule

// File: rtl/bkpt_pair_cmp.sv
module bkpt_pair_cmp
  import bkpt_pkg::*;
#(
  parameter int VAL_W  = 64,
  parameter int CTX_W  = 32,
  parameter int VMID_W = 8
) (
  input  logic [VAL_W-1:0]  val,
  input  ctrl_t             ctrl,
  input  logic [VAL_W-1:0]  ins_addr,
  input  logic              ins_wide,
  input  logic [CTX_W-1:0]  ins_ctx,
  input  logic [VMID_W-1:0] ins_vmid,
  input  logic              mm_as_match,
  output logic              solo_hit,
  output logic              link_req,
  output logic              tgt_ok
);

  localparam int VM_LO = CTX_W;
  localparam int VM_HI = CTX_W + VMID_W - 1;

  logic lane_ok, addr_eq, addr_cond, ctx_eq, vm_eq, ctx_cond, own_cond, usable;

  always_comb begin
    case (ctrl.lane)
      4'h3:    lane_ok = !ins_wide && !ins_addr[1];
      4'hC:    lane_ok = !ins_wide &&  ins_addr[1];
      4'hF:    lane_ok =  ins_wide && !ins_addr[1];
      default: lane_ok = 1'b0;
    endcase
  end

  assign addr_eq   = (val[VAL_W-1:2] == ins_addr[VAL_W-1:2]) && lane_ok;
  assign addr_cond = (ctrl.kind[3:1] == BK_MISM && !mm_as_match) ? !addr_eq : addr_eq;
  assign ctx_eq    = (val[CTX_W-1:0] == ins_ctx);
  assign vm_eq     = (val[VM_HI:VM_LO] == ins_vmid);

  always_comb begin
    case (ctrl.kind[3:1])
      BK_CTX:  ctx_cond = ctx_eq;
      BK_VMID: ctx_cond = vm_eq;
      BK_VCTX: ctx_cond = ctx_eq && vm_eq;
      default: ctx_cond = 1'b0;
    endcase
  end

  assign own_cond = kind_is_addr(ctrl.kind) ? addr_cond : ctx_cond;
  assign usable   = ctrl.en && kind_known(ctrl.kind);

  assign solo_hit = usable && !ctrl.kind[0] && own_cond;
  assign link_req = usable &&  ctrl.kind[0] && kind_is_addr(ctrl.kind) && addr_cond;
  assign tgt_ok   = usable &&  ctrl.kind[0] && kind_is_ctx(ctrl.kind) && ctx_cond;

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int VAL_W     = 64,
  parameter int CTX_W     = 32,
  parameter int VMID_W    = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic                 reg_ctrl,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic [VAL_W-1:0]     reg_wdata,
  output logic [VAL_W-1:0]     reg_rdata,
  output logic                 reg_rvalid,
  input  logic                 ins_valid,
  input  logic [VAL_W-1:0]     ins_addr,
  input  logic                 ins_wide,
  input  logic [CTX_W-1:0]     ins_ctx,
  input  logic [VMID_W-1:0]    ins_vmid,
  input  logic                 mm_as_match,
  output logic                 ev_valid,
  output logic [NUM_PAIRS-1:0] ev_hit
);

  localparam int TGT_N = 2 ** LBN_W;

  logic [NUM_PAIRS-1:0][VAL_W-1:0] val_q;
  ctrl_t [NUM_PAIRS-1:0]           ctrl_q;
  logic [NUM_PAIRS-1:0]            solo, lreq, tgt, hit_d, en_vec, lctx_vec;
  logic [TGT_N-1:0]                tgt_pad;

  bkpt_regs #(.NUM_PAIRS(NUM_PAIRS), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .sel_ctrl(reg_ctrl),
    .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata), .rvalid(reg_rvalid),
    .val_o(val_q), .ctrl_o(ctrl_q)
  );

  assign tgt_pad = TGT_N'(tgt);

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    bkpt_pair_cmp #(.VAL_W(VAL_W), .CTX_W(CTX_W), .VMID_W(VMID_W)) u_cmp (
      .val(val_q[g]), .ctrl(ctrl_q[g]), .ins_addr(ins_addr), .ins_wide(ins_wide),
      .ins_ctx(ins_ctx), .ins_vmid(ins_vmid), .mm_as_match(mm_as_match),
      .solo_hit(solo[g]), .link_req(lreq[g]), .tgt_ok(tgt[g])
    );
    assign hit_d[g]    = solo[g] || (lreq[g] && tgt_pad[ctrl_q[g].lbn]);
    assign en_vec[g]   = ctrl_q[g].en;
    assign lctx_vec[g] = ctrl_q[g].kind[0] && kind_is_ctx(ctrl_q[g].kind);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid <= 1'b0;
      ev_hit   <= '0;
    end else begin
      ev_valid <= ins_valid;
      ev_hit   <= ins_valid ? hit_d : '0;
    end
  end

  // R12: result strobe follows the instruction strobe by one cycle
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ev_valid == $past(ins_valid)));

  // R12: no event bits without a valid result
  a_r12_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (ev_hit != '0) |-> ev_valid);

  // R6: a slot disabled at compare time never reports
  a_r6_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((ev_hit & ~$past(en_vec)) == '0));

  // R10: linked context slots never report on their own bit
  a_r10_link_tgt_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((ev_hit & $past(lctx_vec)) == '0));

endmodule

// File: tb/bkpt_unit_tb.sv
module bkpt_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd, reg_ctrl;
  logic [2:0]  reg_idx;
  logic [63:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic        ins_valid, ins_wide, mm_as_match;
  logic [63:0] ins_addr;
  logic [31:0] ins_ctx;
  logic [7:0]  ins_vmid;
  logic        ev_valid;
  logic [5:0]  ev_hit;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bkpt_unit u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ctrl(reg_ctrl),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .ins_wide(ins_wide), .ins_ctx(ins_ctx), .ins_vmid(ins_vmid),
    .mm_as_match(mm_as_match), .ev_valid(ev_valid), .ev_hit(ev_hit)
  );

  typedef struct packed {
    logic [63:0] a;
    logic        w;
    logic [31:0] c;
    logic [7:0]  v;
    logic [5:0]  e;
  } vec_t;

  // Slot set-up: 0 wide @0x1000, 1 narrow @0x2000, 2 narrow @0x2002,
  // 3 context 0xABCD0001, 4 linked address @0x3000 -> 5, 5 linked VMID 0x42 + ctx 0x55
  localparam vec_t VECS [12] = '{
    '{64'h1000,        1'b1, 32'h0,        8'h00, 6'b000001}, // R5 wide lane
    '{64'h1000,        1'b0, 32'h0,        8'h00, 6'b000000}, // R5 width wrong
    '{64'h1002,        1'b1, 32'h0,        8'h00, 6'b000000}, // R5 wide at +2
    '{64'h2000,        1'b0, 32'h0,        8'h00, 6'b000010}, // R5 select 0x3
    '{64'h2002,        1'b0, 32'h0,        8'h00, 6'b000100}, // R5 select 0xC
    '{64'h2000,        1'b1, 32'h0,        8'h00, 6'b000000}, // R5 narrow lanes, wide insn
    '{64'h0,           1'b1, 32'hABCD0001, 8'h00, 6'b001000}, // R7 context id
    '{64'h3000,        1'b1, 32'h55,       8'h42, 6'b010000}, // R9 R10 linked
    '{64'h3000,        1'b1, 32'h55,       8'h43, 6'b000000}, // R9 VMID off
    '{64'h3000,        1'b1, 32'h56,       8'h42, 6'b000000}, // R9 ctx off
    '{64'h1000,        1'b1, 32'hABCD0001, 8'h00, 6'b001001}, // R5 R7 two slots
    '{64'h1_0000_1000, 1'b1, 32'h0,        8'h00, 6'b000000}  // R5 upper bits
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input int idx, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ctrl = c; reg_idx = 3'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic c, input int idx, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_ctrl = c; reg_idx = 3'(idx);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rvalid ? reg_rdata : 64'hDEAD;
  endtask

  task automatic ins(input logic [63:0] a, input logic w, input logic [31:0] c,
                     input logic [7:0] v, input logic mm, output logic [5:0] h);
    @(negedge clk);
    ins_valid = 1'b1; ins_addr = a; ins_wide = w; ins_ctx = c; ins_vmid = v;
    mm_as_match = mm;
    @(negedge clk);
    ins_valid = 1'b0;
    h = ev_valid ? ev_hit : 6'h3F;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected=<50000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [63:0] d;
    logic [5:0]  h;
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_ctrl = 0; reg_idx = 0; reg_wdata = 0;
    ins_valid = 0; ins_addr = 0; ins_wide = 0; ins_ctx = 0; ins_vmid = 0; mm_as_match = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R4 reset state
    chk("R4 ev_valid", 64'(ev_valid), 64'd0);
    chk("R4 ev_hit", 64'(ev_hit), 64'd0);
    rd(1'b1, 0, d); chk("R4 ctrl0", d, 64'd0);
    rd(1'b0, 5, d); chk("R4 val5", d, 64'd0);

    // R1 R2 R3 readback
    wr(1'b0, 2, 64'hFEDC_BA98_7654_3213); rd(1'b0, 2, d); chk("R1 value 64b", d, 64'hFEDC_BA98_7654_3213);
    wr(1'b1, 0, 64'hFFFF_FFFF_FFFF_FFFF); rd(1'b1, 0, d); chk("R2 reserved zero", d, 64'h00FF_E1E7);
    wr(1'b1, 0, 64'h0A0); rd(1'b1, 0, d); chk("R3 mirror from even", d, 64'h1E0);
    wr(1'b1, 0, 64'h140); rd(1'b1, 0, d); chk("R3 odd bits ignored", d, 64'h0);

    // slot set-up for the vector walk
    wr(1'b0, 0, 64'h1003);              wr(1'b1, 0, 64'h1E1);
    wr(1'b0, 1, 64'h2000);              wr(1'b1, 1, 64'h61);
    wr(1'b0, 2, 64'h2000);              wr(1'b1, 2, 64'h181);
    wr(1'b0, 3, 64'hABCD0001);          wr(1'b1, 3, 64'h2001E1);
    wr(1'b0, 4, 64'h3000);              wr(1'b1, 4, 64'h1501E1);
    wr(1'b0, 5, 64'h42_0000_0055);      wr(1'b1, 5, 64'hB001E1);

    foreach (VECS[i]) begin
      ins(VECS[i].a, VECS[i].w, VECS[i].c, VECS[i].v, 1'b0, h);
      chk($sformatf("R5 R7 R9 vector %0d", i), 64'(h), 64'(VECS[i].e));
    end

    // R12 no strobe, no result
    @(negedge clk); @(negedge clk);
    chk("R12 idle valid", 64'(ev_valid), 64'd0);
    chk("R12 idle hit", 64'(ev_hit), 64'd0);

    // R6 disabled slot
    wr(1'b1, 0, 64'h1E0);
    ins(64'h1000, 1'b1, 32'h0, 8'h0, 1'b0, h); chk("R6 disabled", 64'(h), 64'd0);
    wr(1'b1, 0, 64'h1E1);

    // R8 mismatch on slot 1
    wr(1'b1, 1, 64'h400061);
    ins(64'h2000, 1'b0, 32'h0, 8'h0, 1'b0, h); chk("R8 mismatch equal", 64'(h), 64'd0);
    ins(64'h2004, 1'b0, 32'h0, 8'h0, 1'b0, h); chk("R8 mismatch differ", 64'(h), 64'b000010);
    ins(64'h2004, 1'b0, 32'h0, 8'h0, 1'b1, h); chk("R8 as match differ", 64'(h), 64'd0);
    ins(64'h2000, 1'b0, 32'h0, 8'h0, 1'b1, h); chk("R8 as match equal", 64'(h), 64'b000010);
    wr(1'b1, 1, 64'h61);

    // R9 R10 link target variations
    wr(1'b1, 5, 64'hA001E1);
    ins(64'h3000, 1'b1, 32'h55, 8'h42, 1'b0, h); chk("R9 target unlinked", 64'(h), 64'b100000);
    wr(1'b1, 5, 64'hB001E0);
    ins(64'h3000, 1'b1, 32'h55, 8'h42, 1'b0, h); chk("R9 target disabled", 64'(h), 64'd0);
    wr(1'b1, 5, 64'hB001E1);
    wr(1'b1, 4, 64'h1701E1);
    ins(64'h3000, 1'b1, 32'h55, 8'h42, 1'b0, h); chk("R9 index above 5", 64'(h), 64'd0);
    wr(1'b1, 4, 64'h1001E1);
    ins(64'h3000, 1'b1, 32'h55, 8'h42, 1'b0, h); chk("R9 target address kind", 64'(h), 64'd0);
    wr(1'b1, 4, 64'h1501E1);
    ins(64'h3000, 1'b1, 32'h55, 8'h42, 1'b0, h); chk("R9 restored", 64'(h), 64'b010000);

    // R11 reserved types
    wr(1'b1, 3, 64'h6001E1);
    ins(64'h0, 1'b1, 32'hABCD0001, 8'h0, 1'b0, h); chk("R11 type 0110", 64'(h), 64'd0);
    wr(1'b1, 3, 64'hC001E1);
    ins(64'h0, 1'b1, 32'hABCD0001, 8'h0, 1'b0, h); chk("R11 type 1100", 64'(h), 64'd0);

    // R7 VMID only
    wr(1'b0, 3, 64'h42_0000_0000); wr(1'b1, 3, 64'h8001E1);
    ins(64'h0, 1'b1, 32'h1234, 8'h42, 1'b0, h); chk("R7 vmid equal", 64'(h), 64'b001000);
    ins(64'h0, 1'b1, 32'h0,    8'h41, 1'b0, h); chk("R7 vmid differ", 64'(h), 64'd0);

    finish_run();
  end

endmodule